// File: doc/BRIEF.md
# Serial-Configured Device Bring-Up Sequencer

This block brings an external device out of reset and loads it over a four-wire serial link as the link master. On a start pulse it asserts three active-high resets: the switch core, the PHY and the security module. It holds them for a programmed time and then releases the switch reset alone. After a further settle interval it streams a fixed set of configuration blocks to the device. Each block goes out as one chip-select frame: a write command word followed by payload words. After every block it reads the device's status word and checks the block-level integrity flag.

After the last block a final status read checks the whole-image integrity flag and the image-valid flag. It then issues a fixed list of single-word register writes, clock setup first and pad setup second, and stops in done. A failed check stops it in error with a 4-bit code that names the stage and the block. The delays are counted in system-clock cycles and derived from a clock-frequency parameter. The frame words are computed from parameters, and the block places no meaning on the payload. The PHY and security-module resets are released only by an explicit input once the sequence is done.

Top module: `bringup_seq`

## Requirements
- R1: After rst_ni, busy, done and error are low, the error code is 0, all three reset outputs are high, chip select is high and the serial clock is low.
- R2: A start pulse asserts all three resets. The switch reset stays high for exactly HOLD_CYC = CLK_KHZ*HOLD_US/1000 cycles and then falls, while the PHY and security resets remain high.
- R3: No chip-select activity occurs while the switch reset is high, nor for at least SETTLE_CYC = CLK_KHZ*SETTLE_US/1000 cycles after it falls.
- R4: The link runs in mode 0: the serial clock idles low, data changes while the clock is low, and the receiver samples on the rising edge. Each byte goes out MSB first and each word most significant byte first, with chip select low for the whole frame.
- R5: Block b (0..NUM_BLK-1) is one frame. Its first word is the write command {1'b1, 6'd0, addr[20:0], 4'd0} with addr = CFG_ADDR + b*BLK_WORDS. BLK_WORDS payload words follow, where word i equals PAY_SEED + b*BLK_WORDS + i.
- R6: After each block, a status read frame is sent. It holds the read command {1'b0, 6'd1, 21'd1, 4'd0} and one zero word, and the second word received is the status.
- R7: If status bit 30 is set after block b, the block stops in error with code {2'b01, b[1:0]} and sends no further frames. Bits 28 and 31 are ignored at this point.
- R8: After the last block, one more status read is made. If bit 28 is set the code is 4'b1000. Otherwise, if bit 31 is clear, the code is 4'b1100. Bit 30 is ignored at this point.
- R9: When the final check passes, the block sends NUM_CLK_WR two-word write frames, then NUM_PAD_WR more. Frame k carries the command for CLK_BASE+k and data CLK_DATA+k, and frame j of the pad group carries PAD_BASE+j and data PAD_DATA+j. Done is then raised.
- R10: At most one of busy, done and error is high. The code is 0 unless error is high, and the error and its code hold until the next start.
- R11: The PHY and security resets stay high until release_i is seen while done is high. A release at any other time has no effect.
- R12: A start pulse in any state aborts the current frame. One cycle later chip select is high, all resets are high and busy is set, and the full sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that (re)starts the bring-up |
| release_i | input | 1 | Releases the PHY and security resets when done |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Sequence stopped on a failed check |
| err_code_o | output | 4 | {stage, block}: 01=block check, 10=image integrity, 11=image invalid |
| rst_sw_o | output | 1 | Switch reset, active high |
| rst_phy_o | output | 1 | PHY reset, active high |
| rst_sec_o | output | 1 | Security module reset, active high |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Master data out |
| spi_miso_i | input | 1 | Master data in |

## Verification
The assertions check several rules on every cycle. Chip select must stay idle while the switch is in reset, and the clock must stay low outside a frame. The status flags must be mutually exclusive, and the error code must be zero outside error and frozen inside it. The side resets must stay high until a release in done, and a start must abort cleanly on the next cycle. The exact hold and settle lengths, the bit-exact content and order of every frame, and the choice of error code for each failing status can only be shown by the bench's scenarios. It drives a device model that answers each read with a chosen status and sweeps a failure across every block.

// File: rtl/bu_pkg.sv
package bu_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_SETTLE, S_CFG, S_CHKB, S_CHKG, S_WR, S_DONE, S_ERR
  } seq_st_e;

  typedef enum logic [1:0] {OP_CFG, OP_STAT, OP_REG} op_e;

  localparam logic [20:0] STAT_ADDR = 21'd1;
  localparam int LCRC_BIT  = 30;
  localparam int GCRC_BIT  = 28;
  localparam int VALID_BIT = 31;

  localparam logic [1:0] STG_LOCAL   = 2'b01;
  localparam logic [1:0] STG_GLOBAL  = 2'b10;
  localparam logic [1:0] STG_INVALID = 2'b11;

  function automatic logic [31:0] wr_cmd(input logic [20:0] a);
    return {1'b1, 6'd0, a, 4'd0};
  endfunction

  function automatic logic [31:0] rd_cmd(input logic [20:0] a);
    return {1'b0, 6'd1, a, 4'd0};
  endfunction
endpackage

// File: rtl/bu_spi_byte.sv
module bu_spi_byte (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       abort_i,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  output logic [7:0] rx_o,
  output logic       done_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  logic       act_q, ph_q;
  logic [2:0] cnt_q;
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      sclk_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        act_q  <= 1'b0;
        sclk_o <= 1'b0;
      end else if (go_i && !act_q) begin
        act_q <= 1'b1;
        ph_q  <= 1'b0;
        cnt_q <= '0;
        sh_q  <= tx_i;
      end else if (act_q) begin
        if (!ph_q) begin
          sclk_o <= 1'b1;
          ph_q   <= 1'b1;
        end else begin
          // falling edge: capture input bit, expose next output bit
          sclk_o <= 1'b0;
          ph_q   <= 1'b0;
          sh_q   <= {sh_q[6:0], miso_i};
          cnt_q  <= cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            act_q  <= 1'b0;
            done_o <= 1'b1;
          end
        end
      end
    end
  end

  assign mosi_o = sh_q[7];
  assign rx_o   = sh_q;
endmodule

// File: rtl/bu_spi_frame.sv
module bu_spi_frame #(
  parameter int WW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          go_i,
  input  logic [WW-1:0] nwords_i,
  input  logic [31:0]   word_i,
  output logic [WW-1:0] widx_o,
  output logic [31:0]   rx_word_o,
  output logic          done_o,
  output logic          cs_n_o,
  output logic          bgo_o,
  output logic [7:0]    btx_o,
  input  logic [7:0]    brx_i,
  input  logic          bdone_i
);
  logic       act_q;
  logic [1:0] bidx_q;

  assign btx_o = word_i[(5'd24 - {bidx_q, 3'd0}) +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      bidx_q    <= '0;
      widx_o    <= '0;
      rx_word_o <= '0;
      done_o    <= 1'b0;
      cs_n_o    <= 1'b1;
      bgo_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      bgo_o  <= 1'b0;
      if (abort_i) begin
        act_q  <= 1'b0;
        cs_n_o <= 1'b1;
      end else if (go_i && !act_q) begin
        act_q  <= 1'b1;
        cs_n_o <= 1'b0;
        widx_o <= '0;
        bidx_q <= '0;
        bgo_o  <= 1'b1;
      end else if (act_q && bdone_i) begin
        rx_word_o <= {rx_word_o[23:0], brx_i};
        if (bidx_q == 2'd3) begin
          bidx_q <= '0;
          if (widx_o == nwords_i - WW'(1)) begin
            act_q  <= 1'b0;
            cs_n_o <= 1'b1;
            done_o <= 1'b1;
          end else begin
            widx_o <= widx_o + WW'(1);
            bgo_o  <= 1'b1;
          end
        end else begin
          bidx_q <= bidx_q + 2'd1;
          bgo_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bu_frame_rom.sv
module bu_frame_rom
  import bu_pkg::*;
#(
  parameter int          BLK_WORDS  = 8,
  parameter logic [20:0] CFG_ADDR   = 21'h02000,
  parameter logic [31:0] PAY_SEED   = 32'h5A00_0000,
  parameter int          NUM_CLK_WR = 4,
  parameter logic [20:0] CLK_BASE   = 21'h1_000A,
  parameter logic [31:0] CLK_DATA   = 32'h0A00_0800,
  parameter logic [20:0] PAD_BASE   = 21'h1_0800,
  parameter logic [31:0] PAD_DATA   = 32'h1312_1312,
  parameter int          BLK_W      = 2,
  parameter int          K_W        = 3,
  parameter int          WW         = 4
) (
  input  op_e             op_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [K_W-1:0]   k_i,
  input  logic [WW-1:0]    widx_i,
  output logic [31:0]      word_o,
  output logic [WW-1:0]    nwords_o
);
  logic [31:0] blk_base, reg_a, reg_d;

  always_comb begin
    blk_base = 32'(blk_i) * 32'(BLK_WORDS);
    if (32'(k_i) < 32'(NUM_CLK_WR)) begin
      reg_a = 32'(CLK_BASE) + 32'(k_i);
      reg_d = CLK_DATA + 32'(k_i);
    end else begin
      reg_a = 32'(PAD_BASE) + 32'(k_i) - 32'(NUM_CLK_WR);
      reg_d = PAD_DATA + 32'(k_i) - 32'(NUM_CLK_WR);
    end
    nwords_o = WW'(2);
    word_o   = '0;
    unique case (op_i)
      OP_CFG: begin
        nwords_o = WW'(BLK_WORDS + 1);
        word_o   = (widx_i == '0) ? wr_cmd(21'(32'(CFG_ADDR) + blk_base))
                                  : PAY_SEED + blk_base + 32'(widx_i) - 32'd1;
      end
      OP_STAT: word_o = (widx_i == '0) ? rd_cmd(STAT_ADDR) : 32'd0;
      OP_REG:  word_o = (widx_i == '0) ? wr_cmd(21'(reg_a)) : reg_d;
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/bringup_seq.sv
module bringup_seq
  import bu_pkg::*;
#(
  parameter int          CLK_KHZ    = 50000,
  parameter int          HOLD_US    = 1000,
  parameter int          SETTLE_US  = 1000,
  parameter int          NUM_BLK    = 4,
  parameter int          BLK_WORDS  = 8,
  parameter logic [20:0] CFG_ADDR   = 21'h02000,
  parameter logic [31:0] PAY_SEED   = 32'h5A00_0000,
  parameter int          NUM_CLK_WR = 4,
  parameter logic [20:0] CLK_BASE   = 21'h1_000A,
  parameter logic [31:0] CLK_DATA   = 32'h0A00_0800,
  parameter int          NUM_PAD_WR = 4,
  parameter logic [20:0] PAD_BASE   = 21'h1_0800,
  parameter logic [31:0] PAD_DATA   = 32'h1312_1312
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       release_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [3:0] err_code_o,
  output logic       rst_sw_o,
  output logic       rst_phy_o,
  output logic       rst_sec_o,
  output logic       spi_cs_no,
  output logic       spi_sclk_o,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i
);
  localparam int HOLD_CYC   = CLK_KHZ * HOLD_US / 1000;
  localparam int SETTLE_CYC = CLK_KHZ * SETTLE_US / 1000;
  localparam int MAX_CYC    = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int NUM_WR     = NUM_CLK_WR + NUM_PAD_WR;
  localparam int BLK_W      = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
  localparam int K_W        = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;
  localparam int WW         = $clog2(BLK_WORDS + 2);

  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [BLK_W-1:0] BLK_LAST    = BLK_W'(NUM_BLK - 1);
  localparam logic [K_W-1:0]   K_LAST      = K_W'(NUM_WR - 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] blk_q;
  logic [K_W-1:0]   k_q;
  logic             fgo_q, rel_q;
  logic [3:0]       code_q;
  op_e              op;

  logic [WW-1:0] nwords, widx;
  logic [31:0]   word, rx_word;
  logic          fdone, bgo, bdone;
  logic [7:0]    btx, brx;

  always_comb begin
    unique case (st_q)
      S_CHKB, S_CHKG: op = OP_STAT;
      S_WR:           op = OP_REG;
      default:        op = OP_CFG;
    endcase
  end

  bu_frame_rom #(
    .BLK_WORDS(BLK_WORDS), .CFG_ADDR(CFG_ADDR), .PAY_SEED(PAY_SEED),
    .NUM_CLK_WR(NUM_CLK_WR), .CLK_BASE(CLK_BASE), .CLK_DATA(CLK_DATA),
    .PAD_BASE(PAD_BASE), .PAD_DATA(PAD_DATA),
    .BLK_W(BLK_W), .K_W(K_W), .WW(WW)
  ) u_rom (
    .op_i(op), .blk_i(blk_q), .k_i(k_q), .widx_i(widx),
    .word_o(word), .nwords_o(nwords)
  );

  bu_spi_frame #(.WW(WW)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .abort_i(start_i), .go_i(fgo_q),
    .nwords_i(nwords), .word_i(word), .widx_o(widx), .rx_word_o(rx_word),
    .done_o(fdone), .cs_n_o(spi_cs_no), .bgo_o(bgo), .btx_o(btx),
    .brx_i(brx), .bdone_i(bdone)
  );

  bu_spi_byte u_byte (
    .clk_i(clk_i), .rst_ni(rst_ni), .abort_i(start_i), .go_i(bgo),
    .tx_i(btx), .rx_o(brx), .done_o(bdone), .sclk_o(spi_sclk_o),
    .mosi_o(spi_mosi_o), .miso_i(spi_miso_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      blk_q  <= '0;
      k_q    <= '0;
      fgo_q  <= 1'b0;
      rel_q  <= 1'b0;
      code_q <= '0;
    end else begin
      fgo_q <= 1'b0;
      if (start_i) begin
        st_q   <= S_HOLD;
        cnt_q  <= '0;
        blk_q  <= '0;
        k_q    <= '0;
        rel_q  <= 1'b0;
        code_q <= '0;
      end else begin
        unique case (st_q)
          S_HOLD:
            if (cnt_q == HOLD_LAST) begin
              st_q  <= S_SETTLE;
              cnt_q <= '0;
            end else cnt_q <= cnt_q + CNT_W'(1);
          S_SETTLE:
            if (cnt_q == SETTLE_LAST) begin
              st_q  <= S_CFG;
              fgo_q <= 1'b1;
            end else cnt_q <= cnt_q + CNT_W'(1);
          S_CFG:
            if (fdone) begin
              st_q  <= S_CHKB;
              fgo_q <= 1'b1;
            end
          S_CHKB:
            if (fdone) begin
              if (rx_word[LCRC_BIT]) begin
                st_q   <= S_ERR;
                code_q <= {STG_LOCAL, 2'(blk_q)};
              end else if (blk_q == BLK_LAST) begin
                st_q  <= S_CHKG;
                fgo_q <= 1'b1;
              end else begin
                blk_q <= blk_q + BLK_W'(1);
                st_q  <= S_CFG;
                fgo_q <= 1'b1;
              end
            end
          S_CHKG:
            if (fdone) begin
              if (rx_word[GCRC_BIT]) begin
                st_q   <= S_ERR;
                code_q <= {STG_GLOBAL, 2'b00};
              end else if (!rx_word[VALID_BIT]) begin
                st_q   <= S_ERR;
                code_q <= {STG_INVALID, 2'b00};
              end else begin
                st_q  <= S_WR;
                k_q   <= '0;
                fgo_q <= 1'b1;
              end
            end
          S_WR:
            if (fdone) begin
              if (k_q == K_LAST) st_q <= S_DONE;
              else begin
                k_q   <= k_q + K_W'(1);
                fgo_q <= 1'b1;
              end
            end
          S_DONE: if (release_i) rel_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  logic unused_rx;
  assign unused_rx = ^{rx_word[29], rx_word[27:0]};

  assign busy_o     = (st_q != S_IDLE) && (st_q != S_DONE) && (st_q != S_ERR);
  assign done_o     = (st_q == S_DONE);
  assign err_o      = (st_q == S_ERR);
  assign err_code_o = code_q;
  assign rst_sw_o   = (st_q == S_IDLE) || (st_q == S_HOLD);
  assign rst_phy_o  = !rel_q;
  assign rst_sec_o  = !rel_q;
endmodule

// File: rtl/bu_seq_checker.sv
module bu_seq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       release_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [3:0] err_code_o,
  input logic       rst_sw_o,
  input logic       rst_phy_o,
  input logic       rst_sec_o,
  input logic       spi_cs_no,
  input logic       spi_sclk_o
);
  p_quiet_in_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_sw_o |-> spi_cs_no);

  p_idle_clock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);

  p_err_stage_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_code_o[3:2] != 2'b00);

  p_flags_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_o, err_o}));

  p_code_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> err_code_o == 4'd0);

  p_err_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o && $stable(err_code_o));

  p_side_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> rst_phy_o && rst_sec_o);

  p_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && release_i && !start_i |=> !rst_phy_o && !rst_sec_o);

  p_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && rst_sw_o && rst_phy_o && rst_sec_o && spi_cs_no);
endmodule

bind bringup_seq bu_seq_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .release_i(release_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
  .rst_sw_o(rst_sw_o), .rst_phy_o(rst_phy_o), .rst_sec_o(rst_sec_o),
  .spi_cs_no(spi_cs_no), .spi_sclk_o(spi_sclk_o)
);

// File: tb/tb_bringup_seq.sv
`timescale 1ns/1ps
module tb_bringup_seq;
  localparam int CLK_KHZ = 8;
  localparam int HOLD    = 8;
  localparam int SETTLE  = 8;
  localparam int NB      = 4;
  localparam int BW      = 2;
  localparam logic [20:0] CFG_A = 21'h02000;
  localparam logic [31:0] PAY   = 32'hA500_0010;
  localparam int NCLK = 3;
  localparam logic [20:0] CLK_B = 21'h1_000A;
  localparam logic [31:0] CLK_D = 32'h0A00_0800;
  localparam int NPAD = 2;
  localparam logic [20:0] PAD_B = 21'h1_0800;
  localparam logic [31:0] PAD_D = 32'h1312_1312;
  localparam int GOOD_FRAMES = 2*NB + 1 + NCLK + NPAD;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rel = 1'b0;
  logic busy, done, err, rsw, rphy, rsec, cs_n, sclk, mosi, miso;
  logic [3:0] code;

  always #10 clk = ~clk;

  bringup_seq #(
    .CLK_KHZ(CLK_KHZ), .HOLD_US(1000), .SETTLE_US(1000), .NUM_BLK(NB),
    .BLK_WORDS(BW), .CFG_ADDR(CFG_A), .PAY_SEED(PAY), .NUM_CLK_WR(NCLK),
    .CLK_BASE(CLK_B), .CLK_DATA(CLK_D), .NUM_PAD_WR(NPAD), .PAD_BASE(PAD_B),
    .PAD_DATA(PAD_D)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .release_i(rel),
    .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(code),
    .rst_sw_o(rsw), .rst_phy_o(rphy), .rst_sec_o(rsec), .spi_cs_no(cs_n),
    .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  // device model
  logic [31:0] stat_blk [NB];
  logic [31:0] stat_glb;
  logic [31:0] fw [32][3];
  int          flen [32];
  int nfr = 0, rd_idx = 0, nb = 0, nw = 0;
  logic [95:0] sh = '0;
  logic [31:0] w0, cur_stat;
  logic [63:0] resp;

  assign cur_stat = (rd_idx < NB) ? stat_blk[rd_idx] : stat_glb;
  assign resp     = {32'd0, cur_stat};
  assign miso     = (nb >= 1 && nb <= 64) ? resp[64-nb] : 1'b0;

  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      if (nb > 0) begin
        nw = nb / 32;
        w0 = (nw >= 1) ? 32'(sh >> (32*(nw-1))) : 32'd0;
        if (nfr < 32) begin
          flen[nfr] = nw;
          for (int w = 0; w < 3; w++)
            fw[nfr][w] = (w < nw) ? 32'(sh >> (32*(nw-1-w))) : 32'd0;
        end
        if (nw == 2 && !w0[31]) rd_idx++;
        nfr++;
      end
      nb = 0;
    end else begin
      sh = {sh[94:0], mosi};
      nb++;
    end
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(int i);
    return (i < 2*NB && i % 2 == 0) ? BW + 1 : 2;
  endfunction

  function automatic logic [31:0] exp_word(int i, int w);
    logic [31:0] a, d;
    int k;
    if (i < 2*NB) begin
      if (i % 2 == 0) begin
        a = 32'(CFG_A) + (i/2)*BW;
        return (w == 0) ? {1'b1, 6'd0, a[20:0], 4'd0} : PAY + (i/2)*BW + (w-1);
      end
      return (w == 0) ? {1'b0, 6'd1, 21'd1, 4'd0} : 32'd0;
    end
    if (i == 2*NB) return (w == 0) ? {1'b0, 6'd1, 21'd1, 4'd0} : 32'd0;
    k = i - 2*NB - 1;
    if (k < NCLK) begin a = 32'(CLK_B) + k; d = CLK_D + k; end
    else begin a = 32'(PAD_B) + (k-NCLK); d = PAD_D + (k-NCLK); end
    return (w == 0) ? {1'b1, 6'd0, a[20:0], 4'd0} : d;
  endfunction

  task automatic check_frames(input int n, input string req);
    bit ok;
    chk(nfr == n, req, "frame count", 32'(nfr), 32'(n));
    for (int i = 0; i < n && i < nfr && i < 32; i++) begin
      ok = (flen[i] == exp_len(i));
      for (int w = 0; w < exp_len(i); w++) ok &= (fw[i][w] === exp_word(i, w));
      chk(ok, req, $sformatf("frame %0d word0", i), fw[i][0], exp_word(i, 0));
    end
  endtask

  task automatic pulse_start;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    nfr = 0;
    rd_idx = 0;
  endtask

  task automatic pulse_rel;
    @(negedge clk) rel = 1'b1;
    @(negedge clk) rel = 1'b0;
  endtask

  int hc, sc;
  task automatic measure_and_wait;
    int lim;
    hc = 0;
    while (rsw && hc < 1000) begin
      if (!rphy || !rsec) chk(0, "R2", "side reset during hold", 0, 1);
      @(negedge clk); hc++;
    end
    sc = 0;
    while (cs_n && sc < 1000) begin @(negedge clk); sc++; end
    chk(hc == HOLD, "R2", "switch reset hold cycles", 32'(hc), 32'(HOLD));
    chk(sc >= SETTLE && sc <= SETTLE + 2, "R3", "settle cycles", 32'(sc), 32'(SETTLE + 1));
    lim = 0;
    while (busy && lim < 20000) begin @(negedge clk); lim++; end
    chk(lim < 20000, "R10", "sequence finished", 32'(lim), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_ok;
    for (int b = 0; b < NB; b++) stat_blk[b] = 32'h0;
    stat_glb = 32'h8000_0000;
  endtask

  initial begin
    #3_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int keep;
    set_ok();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({busy, done, err} == 3'b000, "R1", "flags", {busy, done, err}, 0);
    chk(code == 0, "R1", "code", code, 0);
    chk({rsw, rphy, rsec} == 3'b111, "R1", "resets", {rsw, rphy, rsec}, 3'b111);
    chk(cs_n && !sclk, "R1", "link idle", {cs_n, sclk}, 2'b10);
    pulse_rel();
    chk(rphy && rsec, "R11", "release in idle ignored", {rphy, rsec}, 2'b11);

    // good run
    pulse_start();
    measure_and_wait();
    chk(done && !err, "R9", "done", {done, err}, 2'b10);
    check_frames(GOOD_FRAMES, "R5 R6 R9 R4");
    chk(rphy && rsec && !rsw, "R11", "side resets held at done", {rsw, rphy, rsec}, 3'b011);
    pulse_rel();
    chk(!rphy && !rsec, "R11", "release in done", {rphy, rsec}, 0);

    // local check failure at every block
    for (int b = 0; b < NB; b++) begin
      set_ok();
      stat_blk[b] = 32'h4000_0000;
      pulse_start();
      chk(!done && !err && rphy, "R12", "restart clears done/err", {done, err, rphy}, 3'b001);
      measure_and_wait();
      chk(err && !done, "R7", "error flag", {err, done}, 2'b10);
      chk(code == {2'b01, 2'(b)}, "R7", "local code", code, {2'b01, 2'(b)});
      check_frames(2*(b+1), "R7");
      keep = nfr;
      pulse_rel();
      repeat (40) @(negedge clk);
      chk(nfr == keep && err, "R7", "no frames after error", 32'(nfr), 32'(keep));
      chk(rphy && rsec, "R11", "release in error ignored", {rphy, rsec}, 2'b11);
      chk(code == {2'b01, 2'(b)}, "R10", "code held", code, {2'b01, 2'(b)});
    end

    // block reads with bits 28/31 set are ignored
    set_ok();
    for (int b = 0; b < NB; b++) stat_blk[b] = 32'h9000_0000;
    pulse_start();
    measure_and_wait();
    chk(done && !err, "R7", "block read ignores 28/31", {done, err}, 2'b10);

    // final check outcomes
    set_ok(); stat_glb = 32'h9000_0000;
    pulse_start(); measure_and_wait();
    chk(err && code == 4'b1000, "R8", "image integrity", code, 4'b1000);
    check_frames(2*NB + 1, "R8");

    set_ok(); stat_glb = 32'h0000_0000;
    pulse_start(); measure_and_wait();
    chk(err && code == 4'b1100, "R8", "image invalid", code, 4'b1100);

    set_ok(); stat_glb = 32'h1000_0000;
    pulse_start(); measure_and_wait();
    chk(err && code == 4'b1000, "R8", "integrity precedence", code, 4'b1000);

    set_ok(); stat_glb = 32'hC000_0000;
    pulse_start(); measure_and_wait();
    chk(done && !err, "R8", "final read ignores bit 30", {done, err}, 2'b10);
    check_frames(GOOD_FRAMES, "R9");

    // abort mid-frame and rerun
    set_ok();
    pulse_start();
    keep = 0;
    while (cs_n && keep < 1000) begin @(negedge clk); keep++; end
    repeat (30) @(negedge clk);
    chk(!cs_n, "R12", "frame in progress", cs_n, 0);
    pulse_start();
    chk(cs_n && rsw && busy && !sclk, "R12", "abort state", {cs_n, rsw, busy, sclk}, 4'b1110);
    measure_and_wait();
    chk(done && !err, "R12", "rerun completes", {done, err}, 2'b10);
    check_frames(GOOD_FRAMES, "R12");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule